// File: doc/BRIEF.md
# SPI Host Interrupt and Error-Halt Controller

This block sits beside a serial-peripheral host engine and watches what software and the engine do: command submissions with their speed, direction and chip-select fields, pushes into the transmit queue, pops from the receive queue, the two queue fill levels and flags, and the engine's ready and active indications. From these it raises five sticky error flags and six live event conditions. Each set of conditions passes through its own per-bit enable mask and a global enable, giving one error interrupt line and one event interrupt line.

Any latched error stops the host from taking new commands. The host-ready output drops and no command is passed on for issue until software clears every latched flag with a write-one-to-clear acknowledge. Two watermark registers set the queue-level thresholds used by the watermark events. A watermark write whose value exceeds the queue depth is dropped.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Command-busy (error bit 0) is set one cycle after a command write seen while `host_ready_o` is low.
- R2: Overflow (error bit 1) is set one cycle after a TX write while `tx_full_i` is high. Underflow (error bit 2) is set one cycle after an RX read while `rx_empty_i` is high.
- R3: Invalid-command (error bit 3) is set one cycle after a command write in either of two cases. The first is a speed code of 3, where speed 0 is single, 1 is dual and 2 is quad. The second is a direction code of 3 (bidirectional) with a speed other than 0; the other direction codes are 0 dummy, 1 receive and 2 transmit.
- R4: Bad-chip-select (error bit 4) is set one cycle after a command write whose chip-select ID is not below `NUM_CS` (default 2).
- R5: Error flags are sticky. An `err_ack_i` bit clears its flag at the next edge, but a fresh detection in the same cycle keeps the flag set.
- R6: While any error flag is set, `host_ready_o` is low. `cmd_issue_o` is high in the same cycle only for a command write with the host ready, a valid command and a valid chip-select ID.
- R7: The `evt_cond_o` bits track the inputs in the same cycle: bit0 RX full, bit1 TX empty, bit2 RX depth at or above the RX watermark, bit3 TX depth below the TX watermark, bit4 `host_ready_o`, bit5 engine not active.
- R8: `err_irq_o` is high exactly when `err_glb_en_i` is high and some latched error has its mask bit set.
- R9: `evt_irq_o` is high exactly when `evt_glb_en_i` is high and some current event condition has its mask bit set.
- R10: A mask write sets (`mask_set_i`=1) or clears only the selected bits at the next edge; all other mask bits keep their value. Both masks reset to zero.
- R11: The watermarks reset to TX 0 and RX 1. A watermark write takes effect at the next edge, unless its value exceeds `FIFO_DEPTH`, in which case the old value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_speed_i | input | 2 | Command speed code |
| cmd_dir_i | input | 2 | Command direction code |
| cmd_csid_i | input | CSID_W | Command chip-select ID |
| tx_wr_i | input | 1 | TX queue push strobe |
| rx_rd_i | input | 1 | RX queue pop strobe |
| tx_full_i | input | 1 | TX queue full |
| tx_empty_i | input | 1 | TX queue empty |
| rx_full_i | input | 1 | RX queue full |
| rx_empty_i | input | 1 | RX queue empty |
| tx_depth_i | input | DW | TX queue fill level |
| rx_depth_i | input | DW | RX queue fill level |
| engine_ready_i | input | 1 | Engine can accept a command |
| engine_active_i | input | 1 | Engine is executing a command |
| wm_tx_wr_i | input | 1 | TX watermark write strobe |
| wm_rx_wr_i | input | 1 | RX watermark write strobe |
| wm_val_i | input | DW | Watermark write value |
| err_mask_wr_i | input | 1 | Error mask update strobe |
| evt_mask_wr_i | input | 1 | Event mask update strobe |
| mask_set_i | input | 1 | 1 sets, 0 clears the selected mask bits |
| mask_sel_i | input | 6 | Mask bits selected by the update |
| err_glb_en_i | input | 1 | Global error interrupt enable |
| evt_glb_en_i | input | 1 | Global event interrupt enable |
| err_ack_i | input | 5 | Write-one-to-clear error acknowledge |
| err_status_o | output | 5 | Latched error flags |
| err_mask_o | output | 5 | Error enable mask |
| evt_mask_o | output | 6 | Event enable mask |
| evt_cond_o | output | 6 | Live event conditions |
| tx_wm_o | output | DW | TX watermark |
| rx_wm_o | output | DW | RX watermark |
| host_ready_o | output | 1 | Host ready for commands (not halted) |
| cmd_issue_o | output | 1 | Command accepted for issue |
| err_irq_o | output | 1 | Error interrupt |
| evt_irq_o | output | 1 | Event interrupt |

## Verification
Event conditions, the event line, `host_ready_o` and `cmd_issue_o` are combinational and are due in the cycle of the stimulus. Error flags, the error line, the masks and the watermarks are due one edge after the stimulus. The bench drives each stimulus on a falling edge and samples every output 1 ns later. At that point the combinational results reflect the new inputs and the registered results reflect the previous rising edge. The reference state is advanced only at the rising edge that follows, so each output is compared against the value due at that moment.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int ERR_N = 5;
   localparam int EVT_N = 6;

   typedef enum int {
      ERR_CMDBUSY  = 0,
      ERR_TXOVF    = 1,
      ERR_RXUNF    = 2,
      ERR_CMDBAD   = 3,
      ERR_CSBAD    = 4
   } err_bit_e;

   typedef enum int {
      EV_RXFULL  = 0,
      EV_TXEMPTY = 1,
      EV_RXWM    = 2,
      EV_TXWM    = 3,
      EV_READY   = 4,
      EV_IDLE    = 5
   } evt_bit_e;

   typedef enum logic [1:0] {
      SPD_SINGLE = 2'd0,
      SPD_DUAL   = 2'd1,
      SPD_QUAD   = 2'd2,
      SPD_RSVD   = 2'd3
   } speed_e;

   typedef enum logic [1:0] {
      DIR_DUMMY = 2'd0,
      DIR_RX    = 2'd1,
      DIR_TX    = 2'd2,
      DIR_BIDIR = 2'd3
   } dir_e;

   function automatic logic cmd_fields_bad(input logic [1:0] spd, input logic [1:0] dir);
      return (spd == SPD_RSVD) || ((dir == DIR_BIDIR) && (spd != SPD_SINGLE));
   endfunction
endpackage

// File: rtl/spi_irq_mask_reg.sv
module spi_irq_mask_reg #(
   parameter int W = 6
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_i,
   input  logic         set_i,
   input  logic [W-1:0] sel_i,
   output logic [W-1:0] mask_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("mask width must be at least 1");
      end
   endgenerate

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mask_o[b] <= 1'b0;
         end else if (wr_i && sel_i[b]) begin
            mask_o[b] <= set_i;
         end
      end
   end
endmodule

// File: rtl/spi_irq_err_unit.sv
module spi_irq_err_unit
   import spi_irq_pkg::*;
#(
   parameter int NUM_CS = 2,
   parameter int CSID_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_wr_i,
   input  logic [1:0]        cmd_speed_i,
   input  logic [1:0]        cmd_dir_i,
   input  logic [CSID_W-1:0] cmd_csid_i,
   input  logic              tx_wr_i,
   input  logic              tx_full_i,
   input  logic              rx_rd_i,
   input  logic              rx_empty_i,
   input  logic              engine_ready_i,
   input  logic [ERR_N-1:0]  ack_i,
   output logic [ERR_N-1:0]  status_o,
   output logic              host_ready_o,
   output logic              cmd_issue_o
);
   logic [ERR_N-1:0] detect;
   logic             halted;
   logic             fields_bad;
   logic             csid_bad;

   assign halted       = |status_o;
   assign host_ready_o = engine_ready_i & ~halted;
   assign fields_bad   = cmd_fields_bad(cmd_speed_i, cmd_dir_i);
   assign csid_bad     = (32'(cmd_csid_i) >= 32'(NUM_CS));

   always_comb begin
      detect               = '0;
      detect[ERR_CMDBUSY]  = cmd_wr_i & ~host_ready_o;
      detect[ERR_TXOVF]    = tx_wr_i & tx_full_i;
      detect[ERR_RXUNF]    = rx_rd_i & rx_empty_i;
      detect[ERR_CMDBAD]   = cmd_wr_i & fields_bad;
      detect[ERR_CSBAD]    = cmd_wr_i & csid_bad;
   end

   assign cmd_issue_o = cmd_wr_i & host_ready_o & ~fields_bad & ~csid_bad;

   for (genvar e = 0; e < ERR_N; e++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            status_o[e] <= 1'b0;
         end else begin
            status_o[e] <= (status_o[e] & ~ack_i[e]) | detect[e];
         end
      end
   end
endmodule

// File: rtl/spi_irq_evt_unit.sv
module spi_irq_evt_unit
   import spi_irq_pkg::*;
#(
   parameter int FIFO_DEPTH   = 16,
   parameter bit RX_WM_STRICT = 1'b0,
   localparam int DW          = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tx_empty_i,
   input  logic             rx_full_i,
   input  logic [DW-1:0]    tx_depth_i,
   input  logic [DW-1:0]    rx_depth_i,
   input  logic             host_ready_i,
   input  logic             engine_active_i,
   input  logic             wm_tx_wr_i,
   input  logic             wm_rx_wr_i,
   input  logic [DW-1:0]    wm_val_i,
   output logic [DW-1:0]    tx_wm_o,
   output logic [DW-1:0]    rx_wm_o,
   output logic [EVT_N-1:0] cond_o
);
   localparam logic [DW-1:0] DEPTH_MAX = DW'(FIFO_DEPTH);
   logic wm_in_range;
   logic rx_above;

   assign wm_in_range = (wm_val_i <= DEPTH_MAX);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_wm_o <= '0;
         rx_wm_o <= DW'(1);
      end else begin
         if (wm_tx_wr_i && wm_in_range) tx_wm_o <= wm_val_i;
         if (wm_rx_wr_i && wm_in_range) rx_wm_o <= wm_val_i;
      end
   end

   generate
      if (RX_WM_STRICT) begin : g_rx_gt
         assign rx_above = (rx_depth_i > rx_wm_o);
      end else begin : g_rx_ge
         assign rx_above = (rx_depth_i >= rx_wm_o);
      end
   endgenerate

   always_comb begin
      cond_o             = '0;
      cond_o[EV_RXFULL]  = rx_full_i;
      cond_o[EV_TXEMPTY] = tx_empty_i;
      cond_o[EV_RXWM]    = rx_above;
      cond_o[EV_TXWM]    = (tx_depth_i < tx_wm_o);
      cond_o[EV_READY]   = host_ready_i;
      cond_o[EV_IDLE]    = ~engine_active_i;
   end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
   import spi_irq_pkg::*;
#(
   parameter int NUM_CS       = 2,
   parameter int CSID_W       = 2,
   parameter int FIFO_DEPTH   = 16,
   parameter bit RX_WM_STRICT = 1'b0,
   localparam int DW          = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_wr_i,
   input  logic [1:0]        cmd_speed_i,
   input  logic [1:0]        cmd_dir_i,
   input  logic [CSID_W-1:0] cmd_csid_i,
   input  logic              tx_wr_i,
   input  logic              rx_rd_i,
   input  logic              tx_full_i,
   input  logic              tx_empty_i,
   input  logic              rx_full_i,
   input  logic              rx_empty_i,
   input  logic [DW-1:0]     tx_depth_i,
   input  logic [DW-1:0]     rx_depth_i,
   input  logic              engine_ready_i,
   input  logic              engine_active_i,
   input  logic              wm_tx_wr_i,
   input  logic              wm_rx_wr_i,
   input  logic [DW-1:0]     wm_val_i,
   input  logic              err_mask_wr_i,
   input  logic              evt_mask_wr_i,
   input  logic              mask_set_i,
   input  logic [5:0]        mask_sel_i,
   input  logic              err_glb_en_i,
   input  logic              evt_glb_en_i,
   input  logic [4:0]        err_ack_i,
   output logic [4:0]        err_status_o,
   output logic [4:0]        err_mask_o,
   output logic [5:0]        evt_mask_o,
   output logic [5:0]        evt_cond_o,
   output logic [DW-1:0]     tx_wm_o,
   output logic [DW-1:0]     rx_wm_o,
   output logic              host_ready_o,
   output logic              cmd_issue_o,
   output logic              err_irq_o,
   output logic              evt_irq_o
);
   generate
      if (NUM_CS < 1 || NUM_CS > (1 << CSID_W)) begin : g_bad_cs
         $error("NUM_CS must lie in 1 .. 2**CSID_W");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
      if (ERR_N != 5 || EVT_N != 6) begin : g_bad_pkg
         $error("port widths assume 5 error and 6 event conditions");
      end
   endgenerate

   spi_irq_err_unit #(
      .NUM_CS (NUM_CS),
      .CSID_W (CSID_W)
   ) u_err (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .cmd_wr_i       (cmd_wr_i),
      .cmd_speed_i    (cmd_speed_i),
      .cmd_dir_i      (cmd_dir_i),
      .cmd_csid_i     (cmd_csid_i),
      .tx_wr_i        (tx_wr_i),
      .tx_full_i      (tx_full_i),
      .rx_rd_i        (rx_rd_i),
      .rx_empty_i     (rx_empty_i),
      .engine_ready_i (engine_ready_i),
      .ack_i          (err_ack_i),
      .status_o       (err_status_o),
      .host_ready_o   (host_ready_o),
      .cmd_issue_o    (cmd_issue_o)
   );

   spi_irq_evt_unit #(
      .FIFO_DEPTH   (FIFO_DEPTH),
      .RX_WM_STRICT (RX_WM_STRICT)
   ) u_evt (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .tx_empty_i      (tx_empty_i),
      .rx_full_i       (rx_full_i),
      .tx_depth_i      (tx_depth_i),
      .rx_depth_i      (rx_depth_i),
      .host_ready_i    (host_ready_o),
      .engine_active_i (engine_active_i),
      .wm_tx_wr_i      (wm_tx_wr_i),
      .wm_rx_wr_i      (wm_rx_wr_i),
      .wm_val_i        (wm_val_i),
      .tx_wm_o         (tx_wm_o),
      .rx_wm_o         (rx_wm_o),
      .cond_o          (evt_cond_o)
   );

   spi_irq_mask_reg #(.W(ERR_N)) u_err_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (err_mask_wr_i),
      .set_i  (mask_set_i),
      .sel_i  (mask_sel_i[ERR_N-1:0]),
      .mask_o (err_mask_o)
   );

   spi_irq_mask_reg #(.W(EVT_N)) u_evt_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (evt_mask_wr_i),
      .set_i  (mask_set_i),
      .sel_i  (mask_sel_i),
      .mask_o (evt_mask_o)
   );

   assign err_irq_o = err_glb_en_i & |(err_status_o & err_mask_o);
   assign evt_irq_o = evt_glb_en_i & |(evt_cond_o & evt_mask_o);
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk #(
   parameter int FIFO_DEPTH = 16,
   parameter int DW         = 5
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          cmd_wr_i,
   input logic          tx_wr_i,
   input logic          tx_full_i,
   input logic          rx_rd_i,
   input logic          rx_empty_i,
   input logic          wm_tx_wr_i,
   input logic [DW-1:0] wm_val_i,
   input logic [4:0]    err_ack_i,
   input logic [4:0]    err_status_o,
   input logic [DW-1:0] tx_wm_o,
   input logic          host_ready_o,
   input logic          cmd_issue_o,
   input logic          err_glb_en_i,
   input logic          err_irq_o
);
   assert_busy_latch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_wr_i && !host_ready_o) |=> err_status_o[0]);

   assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_wr_i && tx_full_i) |=> err_status_o[1]);

   assert_no_underflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_rd_i && rx_empty_i) |=> err_status_o[2]);

   assert_sticky_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_status_o[1] && !err_ack_i[1]) |=> err_status_o[1]);

   assert_halt_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_status_o != 5'd0) |-> (!host_ready_o && !cmd_issue_o));

   assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!err_glb_en_i || err_status_o == 5'd0) |-> !err_irq_o);

   assert_wm_keep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wm_tx_wr_i && (32'(wm_val_i) > FIFO_DEPTH)) |=> $stable(tx_wm_o));
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .DW         (DW)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .cmd_wr_i     (cmd_wr_i),
   .tx_wr_i      (tx_wr_i),
   .tx_full_i    (tx_full_i),
   .rx_rd_i      (rx_rd_i),
   .rx_empty_i   (rx_empty_i),
   .wm_tx_wr_i   (wm_tx_wr_i),
   .wm_val_i     (wm_val_i),
   .err_ack_i    (err_ack_i),
   .err_status_o (err_status_o),
   .tx_wm_o      (tx_wm_o),
   .host_ready_o (host_ready_o),
   .cmd_issue_o  (cmd_issue_o),
   .err_glb_en_i (err_glb_en_i),
   .err_irq_o    (err_irq_o)
);

// File: tb/spi_irq_ctrl_test.sv
module spi_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCS = 2;
   localparam int DEP = 16;
   localparam int W   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic cmd_wr, tx_wr, rx_rd, tx_full, tx_empty, rx_full, rx_empty;
   logic [1:0] spd, dir;
   logic [1:0] csid;
   logic [W-1:0] tx_dep, rx_dep, wm_val;
   logic eng_rdy, eng_act, wm_tx_wr, wm_rx_wr, emask_wr, vmask_wr, mset, eglb, vglb;
   logic [5:0] msel;
   logic [4:0] ack;
   logic [4:0] st, emask;
   logic [5:0] vmask, cond;
   logic [W-1:0] txwm, rxwm;
   logic hrdy, issue, eirq, virq;

   spi_irq_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_speed_i(spd), .cmd_dir_i(dir),
      .cmd_csid_i(csid), .tx_wr_i(tx_wr), .rx_rd_i(rx_rd), .tx_full_i(tx_full),
      .tx_empty_i(tx_empty), .rx_full_i(rx_full), .rx_empty_i(rx_empty),
      .tx_depth_i(tx_dep), .rx_depth_i(rx_dep), .engine_ready_i(eng_rdy),
      .engine_active_i(eng_act), .wm_tx_wr_i(wm_tx_wr), .wm_rx_wr_i(wm_rx_wr),
      .wm_val_i(wm_val), .err_mask_wr_i(emask_wr), .evt_mask_wr_i(vmask_wr),
      .mask_set_i(mset), .mask_sel_i(msel), .err_glb_en_i(eglb), .evt_glb_en_i(vglb),
      .err_ack_i(ack), .err_status_o(st), .err_mask_o(emask), .evt_mask_o(vmask),
      .evt_cond_o(cond), .tx_wm_o(txwm), .rx_wm_o(rxwm), .host_ready_o(hrdy),
      .cmd_issue_o(issue), .err_irq_o(eirq), .evt_irq_o(virq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [4:0]   m_err;
   logic [4:0]   m_emask;
   logic [5:0]   m_vmask;
   logic [W-1:0] m_txwm, m_rxwm;

   function automatic logic f_bad(input logic [1:0] s, input logic [1:0] d);
      return (s == 2'd3) || (d == 2'd3 && s != 2'd0);
   endfunction
   function automatic logic f_hrdy();
      return eng_rdy && (m_err == 5'd0);
   endfunction
   function automatic logic [5:0] f_cond();
      logic [5:0] c;
      c[0] = rx_full;
      c[1] = tx_empty;
      c[2] = (rx_dep >= m_rxwm);
      c[3] = (tx_dep < m_txwm);
      c[4] = f_hrdy();
      c[5] = !eng_act;
      return c;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      cmd_wr = 0; tx_wr = 0; rx_rd = 0; tx_full = 0; tx_empty = 1; rx_full = 0; rx_empty = 1;
      spd = 0; dir = 0; csid = 0; tx_dep = 0; rx_dep = 0; wm_val = 0;
      eng_rdy = 1; eng_act = 0; wm_tx_wr = 0; wm_rx_wr = 0; emask_wr = 0; vmask_wr = 0;
      mset = 0; msel = 0; eglb = 1; vglb = 1; ack = 0;
   endtask

   task automatic rand_inputs();
      cmd_wr  = ($urandom % 3) == 0;
      spd     = 2'($urandom); dir = 2'($urandom); csid = 2'($urandom);
      tx_dep  = W'($urandom % (DEP + 1)); rx_dep = W'($urandom % (DEP + 1));
      tx_full = (tx_dep == W'(DEP)); tx_empty = (tx_dep == 0);
      rx_full = (rx_dep == W'(DEP)); rx_empty = (rx_dep == 0);
      tx_wr   = ($urandom % 3) == 0; rx_rd = ($urandom % 3) == 0;
      eng_rdy = ($urandom % 4) != 0; eng_act = ($urandom % 2) == 0;
      wm_tx_wr = ($urandom % 8) == 0; wm_rx_wr = ($urandom % 8) == 0;
      wm_val  = W'($urandom);
      emask_wr = ($urandom % 6) == 0; vmask_wr = ($urandom % 6) == 0;
      mset    = 1'($urandom); msel = 6'($urandom);
      eglb    = ($urandom % 5) != 0; vglb = ($urandom % 5) != 0;
      ack     = (($urandom % 3) == 0) ? 5'h1f : 5'($urandom);
   endtask

   task automatic check_outputs();
      logic [5:0] c;
      logic hr;
      c  = f_cond();
      hr = f_hrdy();
      chk(32'(st), 32'(m_err), "R1/R2/R3/R4/R5 err_status");
      chk(32'(hrdy), 32'(hr), "R6 host_ready");
      chk(32'(issue), 32'(cmd_wr && hr && !f_bad(spd, dir) && csid < 2'(NCS)), "R6 cmd_issue");
      chk(32'(cond), 32'(c), "R7 evt_cond");
      chk(32'(eirq), 32'(eglb && ((m_err & m_emask) != 0)), "R8 err_irq");
      chk(32'(virq), 32'(vglb && ((c & m_vmask) != 0)), "R9 evt_irq");
      chk(32'({m_vmask, m_emask}), 32'({vmask, emask}), "R10 masks");
      chk(32'({txwm, rxwm}), 32'({m_txwm, m_rxwm}), "R11 watermarks");
   endtask

   task automatic model_edge();
      logic [4:0] det;
      det[0] = cmd_wr && !f_hrdy();
      det[1] = tx_wr && tx_full;
      det[2] = rx_rd && rx_empty;
      det[3] = cmd_wr && f_bad(spd, dir);
      det[4] = cmd_wr && (csid >= 2'(NCS));
      m_err = (m_err & ~ack) | det;
      if (emask_wr) m_emask = mset ? (m_emask | msel[4:0]) : (m_emask & ~msel[4:0]);
      if (vmask_wr) m_vmask = mset ? (m_vmask | msel) : (m_vmask & ~msel);
      if (wm_tx_wr && wm_val <= W'(DEP)) m_txwm = wm_val;
      if (wm_rx_wr && wm_val <= W'(DEP)) m_rxwm = wm_val;
   endtask

   // inputs already set by caller at the falling edge
   task automatic cycle();
      #1;
      check_outputs();
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234abcd));
      idle_inputs();
      m_err = 0; m_emask = 0; m_vmask = 0; m_txwm = 0; m_rxwm = W'(1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(32'(st), 0, "R5 reset status");
      chk(32'({txwm, rxwm}), 32'({W'(0), W'(1)}), "R11 reset watermarks");
      chk(32'({vmask, emask}), 0, "R10 reset masks");

      // R3: bidirectional at dual speed
      idle_inputs(); cmd_wr = 1; dir = 2'd3; spd = 2'd1; cycle();
      idle_inputs(); #1; chk(32'(st), 32'h08, "R3 bidir dual"); chk(32'(hrdy), 0, "R6 halted");
      // R1: command while halted, ack of bit3 in same cycle
      cmd_wr = 1; ack = 5'h08; cycle();
      idle_inputs(); #1; chk(32'(st), 32'h01, "R1 busy while halted");
      ack = 5'h1f; cycle();
      idle_inputs(); #1; chk(32'(hrdy), 1, "R5 ack releases halt");
      // R4: bad chip select
      cmd_wr = 1; csid = 2'd2; cycle();
      idle_inputs(); #1; chk(32'(st), 32'h10, "R4 csid 2");
      // R5: ack loses against fresh detection
      tx_wr = 1; tx_full = 1; ack = 5'h1f; cycle();
      idle_inputs(); #1; chk(32'(st), 32'h02, "R5 detect beats ack");
      ack = 5'h1f; cycle();
      idle_inputs();
      // R10: set bit 2 then bit 0, bit 2 kept
      emask_wr = 1; mset = 1; msel = 6'h04; cycle();
      idle_inputs(); emask_wr = 1; mset = 1; msel = 6'h01; cycle();
      idle_inputs(); #1; chk(32'(emask), 32'h05, "R10 other bits kept");
      // R11: out-of-range watermark ignored, in-range accepted
      wm_tx_wr = 1; wm_val = W'(DEP + 1); cycle();
      idle_inputs(); #1; chk(32'(txwm), 0, "R11 wm 17 ignored");
      wm_tx_wr = 1; wm_val = W'(DEP); cycle();
      idle_inputs(); #1; chk(32'(txwm), 32'(DEP), "R11 wm 16 taken");
      // R8: masked underflow raises the error line
      rx_rd = 1; rx_empty = 1; cycle();
      idle_inputs(); #1; chk(32'(eirq), 1, "R8 underflow irq");
      ack = 5'h1f; cycle();
      idle_inputs();

      for (int i = 0; i < 3000; i++) begin
         rand_inputs();
         cycle();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule